// File: doc/BRIEF.md
# Up/Down Timer Base with Shadowed Reload

The block is the time base of a general-purpose timer. A prescaler divides the clock. The divided tick steps a counter up or down. The counter wraps at a programmable reload limit. Three settings each have two copies: the reload limit, the prescaler divisor and one compare value. Software writes a preload copy. The logic works from an active copy. An update event copies every preload into its active copy and sends out a single-cycle pulse. Three things can raise an update: a counter wrap, a software generate request, or a reset request from a slave controller. A disable bit blocks the update event and freezes the active copies. A software or slave reset still restarts the counter and the prescaler while the update is disabled.

Software uses a simple write port and a registered read port. The read port returns the control bits, the preloads and the active copies. A trigger input can start the counter without a software write. The block also forms a TI1 signal from three channel pins. The signal is either channel 1 alone or the XOR of all three pins.

Top module: `tmr_base_unit`

## Requirements
- R1: After the synchronous reset, the following values hold: cnt_o = 0, upd_o = 0, ti1_o = 0, the control register reads 0, the event register reads 0, the reload preload and active reload read 0xFFFF, and the divisor and compare registers (preload and active) read 0.
- R2: When the run bit (control bit 0) is 1, the counter takes one step every (active divisor + 1) clock cycles. When the run bit is 0, the counter and the prescaler hold.
- R3: With the direction bit (control bit 2) at 0, the counter counts up to the active reload and then wraps to 0. With it at 1, the counter counts down to 0 and then wraps to the active reload.
- R4: With the update-off bit (control bit 1) at 0, an update event happens on three conditions: a counter wrap, a software generate request (writing 1 to bit 0 at address 1), or a high slv_reset. Each update event drives upd_o high for exactly the following cycle.
- R5: An update event loads the active reload, divisor and compare values from their preloads. A preload write has no effect on the active values at addresses 5, 6 and 7 until the next update.
- R6: With the update-off bit at 1, upd_o never goes high, and the active reload, divisor and compare values keep their contents.
- R7: A generate request or slv_reset restarts the count whatever the update-off bit is. The prescaler count clears. The counter loads 0 in up mode. In down mode it loads the active reload, or the preload when the restart also raises an update. A restart takes priority over a wrap in the same cycle.
- R8: A generate request acts in the cycle after its write and then clears by itself, so address 1 reads 0 afterwards.
- R9: A high slv_trig sets the run bit at the next edge, with no software write.
- R10: With the TI1 select bit (control bit 3) at 0, ti1_o follows ch_pin[0]. With it at 1, ti1_o is the XOR of ch_pin[2:0]. Either way ti1_o is registered, one cycle after the pins.
- R11: rd_data shows the register at rd_addr one cycle later. The address map is: 0 control, 1 event, 2 reload preload, 3 divisor preload, 4 compare preload, 5 active reload, 6 active divisor, 7 active compare. Unused control and event bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Registered read data |
| slv_reset | input | 1 | Reset request from slave controller |
| slv_trig | input | 1 | Trigger that sets the run bit |
| ch_pin | input | 3 | Channel input pins 1..3 (bit 0 is channel 1) |
| cnt_o | output | 16 | Counter value |
| upd_o | output | 1 | Update event pulse |
| ti1_o | output | 1 | Registered TI1 signal |

## Verification
Two functions can meet in one cycle: a restart request (slv_reset or a pending generate) and the natural counter wrap. The bench sends a slv_reset pulse at every offset across a counting period, so one pulse lands on the wrap cycle. It does this in both up and down mode. A reference model built from the requirements judges each case. The model expects a single upd_o pulse. It expects the restart value in the counter, not the wrap value. In down mode, it expects the new preload to be used.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int A_CTL  = 0;
  localparam int A_EVT  = 1;
  localparam int A_PRE0 = 2;
  localparam int A_ACT0 = 5;
  localparam int N_SHD  = 3;

  typedef struct packed {
    logic tsel;
    logic dir;
    logic upd_off;
    logic run;
  } tmr_ctl_t;

  localparam int CTL_W = $bits(tmr_ctl_t);

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         clr,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] pc_q;

  assign tick = run && (pc_q == div);

  always_ff @(posedge clk) begin
    if (rst)       pc_q <= '0;
    else if (clr)  pc_q <= '0;
    else if (run)  pc_q <= tick ? '0 : pc_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         reinit,
  input  logic         down,
  input  logic [W-1:0] top_val,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q;

  assign cnt  = cnt_q;
  assign wrap = tick && (down ? (cnt_q == '0) : (cnt_q == top_val));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (reinit) begin
      cnt_q <= down ? reload_val : '0;
    end else if (tick) begin
      if (down) cnt_q <= wrap ? top_val : cnt_q - 1'b1;
      else      cnt_q <= wrap ? '0      : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_shadow.sv
module tmr_shadow #(
  parameter int         W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load,
  output logic [W-1:0] pre,
  output logic [W-1:0] act
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pre <= RST_VAL;
      act <= RST_VAL;
    end else begin
      if (wr)   pre <= wdata;
      if (load) act <= pre;
    end
  end
endmodule

// File: rtl/tmr_ti_sel.sv
module tmr_ti_sel #(
  parameter int N_CH = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel_xor,
  input  logic [N_CH-1:0] pins,
  output logic            ti
);
  always_ff @(posedge clk) begin
    if (rst) ti <= 1'b0;
    else     ti <= sel_xor ? ^pins : pins[0];
  end
endmodule

// File: rtl/tmr_base_unit.sv
module tmr_base_unit
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3,
  parameter int N_CH   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              slv_reset,
  input  logic              slv_trig,
  input  logic [N_CH-1:0]   ch_pin,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              upd_o,
  output logic              ti1_o
);
  localparam logic [CNT_W-1:0] ARR_RST = '1;

  tmr_ctl_t ctl_q;
  logic     ugen_q;
  logic     run_q, upd_off_q, dir_q, tsel_q;
  logic     reinit, wrap, tick, upd_ev;
  logic [N_SHD-1:0][CNT_W-1:0] pre_v, act_v;
  logic [CNT_W-1:0] arr_pre, arr_act, psc_pre, psc_act, cmp_pre, cmp_act;
  logic [CNT_W-1:0] reload_val;

  assign run_q     = ctl_q.run;
  assign upd_off_q = ctl_q.upd_off;
  assign dir_q     = ctl_q.dir;
  assign tsel_q    = ctl_q.tsel;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      ugen_q <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADDR_W'(A_CTL)) ctl_q <= tmr_ctl_t'(wr_data[CTL_W-1:0]);
      if (slv_trig) ctl_q.run <= 1'b1;
      ugen_q <= wr_en && (wr_addr == ADDR_W'(A_EVT)) && wr_data[0];
    end
  end

  assign reinit = ugen_q || slv_reset;
  assign upd_ev = !upd_off_q && (reinit || wrap);

  for (genvar g = 0; g < N_SHD; g++) begin : g_shd
    tmr_shadow #(
      .W      (CNT_W),
      .RST_VAL((g == 0) ? ARR_RST : '0)
    ) shd_i (
      .clk  (clk),
      .rst  (rst),
      .wr   (wr_en && (wr_addr == ADDR_W'(A_PRE0 + g))),
      .wdata(wr_data),
      .load (upd_ev),
      .pre  (pre_v[g]),
      .act  (act_v[g])
    );
  end

  assign arr_pre = pre_v[0];
  assign psc_pre = pre_v[1];
  assign cmp_pre = pre_v[2];
  assign arr_act = act_v[0];
  assign psc_act = act_v[1];
  assign cmp_act = act_v[2];

  assign reload_val = upd_ev ? arr_pre : arr_act;

  tmr_prescaler #(.W(CNT_W)) psc_i (
    .clk (clk),
    .rst (rst),
    .run (run_q),
    .clr (reinit),
    .div (psc_act),
    .tick(tick)
  );

  tmr_counter #(.W(CNT_W)) cnt_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .reinit    (reinit),
    .down      (dir_q),
    .top_val   (arr_act),
    .reload_val(reload_val),
    .cnt       (cnt_o),
    .wrap      (wrap)
  );

  tmr_ti_sel #(.N_CH(N_CH)) ti_i (
    .clk    (clk),
    .rst    (rst),
    .sel_xor(tsel_q),
    .pins   (ch_pin),
    .ti     (ti1_o)
  );

  always_ff @(posedge clk) begin
    if (rst) upd_o <= 1'b0;
    else     upd_o <= upd_ev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (int'(rd_addr))
        A_CTL:      rd_data <= CNT_W'(ctl_q);
        A_EVT:      rd_data <= CNT_W'(ugen_q);
        A_PRE0:     rd_data <= arr_pre;
        A_PRE0 + 1: rd_data <= psc_pre;
        A_PRE0 + 2: rd_data <= cmp_pre;
        A_ACT0:     rd_data <= arr_act;
        A_ACT0 + 1: rd_data <= psc_act;
        A_ACT0 + 2: rd_data <= cmp_act;
        default:    rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_base_chk.sv
module tmr_base_chk #(
  parameter int CNT_W = 16,
  parameter int N_CH  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             upd_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             slv_reset,
  input logic             slv_trig,
  input logic [N_CH-1:0]  ch_pin,
  input logic             ti1_o,
  input logic             run_q,
  input logic             upd_off_q,
  input logic             dir_q,
  input logic             tsel_q,
  input logic             ugen_q,
  input logic [CNT_W-1:0] arr_pre,
  input logic [CNT_W-1:0] arr_act,
  input logic [CNT_W-1:0] psc_pre,
  input logic [CNT_W-1:0] psc_act,
  input logic [CNT_W-1:0] cmp_pre,
  input logic [CNT_W-1:0] cmp_act
);
  a_r6_no_pulse_when_off: assert property (@(posedge clk) disable iff (rst)
    upd_off_q |=> !upd_o);

  a_r6_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    upd_off_q |=> ($stable(arr_act) && $stable(psc_act) && $stable(cmp_act)));

  a_r5_load_from_preload: assert property (@(posedge clk) disable iff (rst)
    upd_o |-> (arr_act == $past(arr_pre) && psc_act == $past(psc_pre) && cmp_act == $past(cmp_pre)));

  a_r7_reinit_up: assert property (@(posedge clk) disable iff (rst)
    ((ugen_q || slv_reset) && !dir_q) |=> (cnt_o == '0));

  a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !ugen_q && !slv_reset) |=> $stable(cnt_o));

  a_r9_trigger_sets_run: assert property (@(posedge clk) disable iff (rst)
    slv_trig |=> run_q);

  a_r10_ti1_direct: assert property (@(posedge clk) disable iff (rst)
    !tsel_q |=> (ti1_o == $past(ch_pin[0])));

  a_r8_gen_self_clear: assert property (@(posedge clk) disable iff (rst)
    ugen_q |=> !ugen_q);
endmodule

bind tmr_base_unit tmr_base_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .upd_o    (upd_o),
  .cnt_o    (cnt_o),
  .slv_reset(slv_reset),
  .slv_trig (slv_trig),
  .ch_pin   (ch_pin),
  .ti1_o    (ti1_o),
  .run_q    (run_q),
  .upd_off_q(upd_off_q),
  .dir_q    (dir_q),
  .tsel_q   (tsel_q),
  .ugen_q   (ugen_q),
  .arr_pre  (arr_pre),
  .arr_act  (arr_act),
  .psc_pre  (psc_pre),
  .psc_act  (psc_act),
  .cmp_pre  (cmp_pre),
  .cmp_act  (cmp_act)
);

// File: tb/tmr_base_unit_tb_top.sv
module tmr_base_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        slv_reset = 1'b0;
  logic        slv_trig = 1'b0;
  logic [2:0]  ch_pin = '0;
  logic [15:0] cnt_o;
  logic        upd_o;
  logic        ti1_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_base_unit dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .slv_reset(slv_reset), .slv_trig(slv_trig),
    .ch_pin(ch_pin), .cnt_o(cnt_o), .upd_o(upd_o), .ti1_o(ti1_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Reference model written from the requirements
  logic        m_run, m_off, m_dir, m_tsel, m_ugen, m_upd, m_ti1;
  logic [15:0] m_pc, m_cnt, m_arr_p, m_arr_a, m_psc_p, m_psc_a;
  logic        m_rein, m_tick, m_wrp, m_ev;

  always @(posedge clk) begin
    if (rst) begin
      m_run <= 0; m_off <= 0; m_dir <= 0; m_tsel <= 0; m_ugen <= 0;
      m_upd <= 0; m_ti1 <= 0; m_pc <= 0; m_cnt <= 0;
      m_arr_p <= 16'hFFFF; m_arr_a <= 16'hFFFF; m_psc_p <= 0; m_psc_a <= 0;
    end else begin
      m_rein = m_ugen || slv_reset;
      m_tick = m_run && (m_pc == m_psc_a);
      m_wrp  = m_tick && (m_dir ? (m_cnt == 0) : (m_cnt == m_arr_a));
      m_ev   = !m_off && (m_rein || m_wrp);
      if (m_rein)      m_pc <= 0;
      else if (m_run)  m_pc <= m_tick ? 16'd0 : m_pc + 16'd1;
      if (m_rein)      m_cnt <= m_dir ? (m_ev ? m_arr_p : m_arr_a) : 16'd0;
      else if (m_tick) m_cnt <= m_dir ? (m_wrp ? m_arr_a : m_cnt - 16'd1)
                                      : (m_wrp ? 16'd0 : m_cnt + 16'd1);
      if (m_ev) begin m_arr_a <= m_arr_p; m_psc_a <= m_psc_p; end
      m_upd  <= m_ev;
      m_ti1  <= m_tsel ? ^ch_pin : ch_pin[0];
      m_ugen <= wr_en && wr_addr == 3'd1 && wr_data[0];
      if (wr_en && wr_addr == 3'd0) {m_tsel, m_dir, m_off, m_run} <= wr_data[3:0];
      if (slv_trig) m_run <= 1'b1;
      if (wr_en && wr_addr == 3'd2) m_arr_p <= wr_data;
      if (wr_en && wr_addr == 3'd3) m_psc_p <= wr_data;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cnt_o == m_cnt, "R2/R3/R7 cnt_o", cnt_o, m_cnt);
      chk(upd_o == m_upd, "R4/R6 upd_o", upd_o, m_upd);
      chk(ti1_o == m_ti1, "R10 ti1_o", ti1_o, m_ti1);
    end
  end

  // Read scoreboard: driver pushes expectations, monitor pops and compares
  typedef struct { logic [15:0] exp; string tag; } rd_item_t;
  rd_item_t rd_q[$];
  logic rd_req = 1'b0;
  logic rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= rd_req;

  always @(negedge clk) begin
    if (rd_seen && rd_q.size() > 0) begin
      rd_item_t it;
      it = rd_q.pop_front();
      chk(rd_data == it.exp, it.tag, rd_data, it.exp);
    end
  end

  task automatic rd(input logic [2:0] a, input logic [15:0] e, input string tag);
    rd_item_t it;
    @(negedge clk);
    rd_addr = a; rd_req = 1'b1;
    it.exp = e; it.tag = tag;
    rd_q.push_back(it);
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_slv_reset();
    @(negedge clk); slv_reset = 1'b1;
    @(negedge clk); slv_reset = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(3'd0, 16'h0000, "R1 ctl");
    rd(3'd1, 16'h0000, "R1 evt");
    rd(3'd2, 16'hFFFF, "R1 arr pre");
    rd(3'd5, 16'hFFFF, "R1 arr act");
    rd(3'd6, 16'h0000, "R1 psc act");
    rd(3'd7, 16'h0000, "R1 cmp act");
    // R5 preload not visible until update
    wr(3'd2, 16'd5); wr(3'd3, 16'd0); wr(3'd4, 16'h1234);
    rd(3'd5, 16'hFFFF, "R5 arr hidden");
    rd(3'd7, 16'h0000, "R5 cmp hidden");
    rd(3'd2, 16'd5, "R11 arr pre");
    rd(3'd4, 16'h1234, "R11 cmp pre");
    // R4/R8 software generate
    wr(3'd1, 16'd1);
    idle(2);
    rd(3'd5, 16'd5, "R5 arr loaded");
    rd(3'd7, 16'h1234, "R5 cmp loaded");
    rd(3'd1, 16'd0, "R8 gen cleared");
    // R2/R3 up counting, prescaler change
    wr(3'd0, 16'h0001);
    idle(20);
    wr(3'd3, 16'd2);
    idle(20);
    rd(3'd6, 16'd2, "R5 psc loaded");
    wr(3'd0, 16'h0000);
    idle(8);
    // R6 update off
    wr(3'd0, 16'h0003);
    wr(3'd2, 16'd3);
    idle(40);
    rd(3'd5, 16'd5, "R6 arr held");
    wr(3'd1, 16'd1);
    idle(3);
    rd(3'd5, 16'd5, "R6 arr held after gen");
    pulse_slv_reset();
    idle(3);
    rd(3'd6, 16'd2, "R6 psc held");
    // R7 slave reset with update on
    wr(3'd0, 16'h0001);
    idle(2);
    pulse_slv_reset();
    idle(2);
    rd(3'd5, 16'd3, "R5 arr via slave reset");
    // collide restart with wrap, up then down
    wr(3'd3, 16'd0); wr(3'd1, 16'd1);
    for (int k = 0; k < 6; k++) begin idle(k); pulse_slv_reset(); end
    wr(3'd0, 16'h0005);
    wr(3'd2, 16'd4);
    idle(12);
    for (int k = 0; k < 7; k++) begin idle(k); pulse_slv_reset(); end
    wr(3'd1, 16'd1);
    idle(10);
    // R10 TI1 select
    for (int v = 0; v < 8; v++) begin @(negedge clk); ch_pin = 3'(v); end
    wr(3'd0, 16'h0009);
    for (int v = 0; v < 8; v++) begin @(negedge clk); ch_pin = 3'(v); end
    idle(2);
    // R9 trigger
    wr(3'd0, 16'h0000);
    idle(3);
    @(negedge clk); slv_trig = 1'b1;
    @(negedge clk); slv_trig = 1'b0;
    rd(3'd0, 16'h0001, "R9 run set by trigger");
    idle(10);
    // R11 unused bits
    wr(3'd0, 16'hFFFF);
    rd(3'd0, 16'h000F, "R11 ctl unused bits");
    wr(3'd1, 16'hFFFE);
    rd(3'd1, 16'h0000, "R11 evt unused bits");
    idle(4);
    finish_run();
  end
endmodule